// File: doc/BRIEF.md
# Effective Address Generator

This block forms a 64-bit memory address from up to three terms: a base register value, an index register value scaled by a power of two, and a sign-extended constant offset. Each term can be switched off on its own. Two other modes are also available. The first adds a signed 32-bit offset to the address of the instruction that follows the current one. The second takes a sign-extended 32-bit constant as the whole address. The requester decodes the instruction and supplies the operand values, the field codes and the next-instruction address.

A request is accepted on a clock edge and the result appears one clock later. The requester tags each request as either a memory address or an arithmetic result. A memory address comes out on the address port with an address strobe. An arithmetic result comes out on a separate data port with its own strobe and raises no address strobe. The block has no condition-flag port, so neither kind of result can change any flag. All sums wrap modulo 2^64, and the block gives no carry or overflow indication.

Top module: `addr_gen_unit`

## Requirements
- R1: When `mode` is 0 or 3, the result is the sum of the enabled terms: `base_val` when `base_en` is 1, the scaled index, and the extended offset when `disp_en` is 1. A disabled term contributes zero.
- R2: The scale code `scale` multiplies the index value by 1, 2, 4 or 8 for codes 0, 1, 2 and 3. The index term is present only when `idx_en` is 1.
- R3: When `idx_sel` equals 4, the stack-pointer register number, the index term is zero even if `idx_en` is 1.
- R4: When `disp_wide` is 0, the offset is `disp[7:0]` sign-extended to 64 bits. When `disp_wide` is 1, the offset is `disp[31:0]` sign-extended to 64 bits.
- R5: When `mode` is 1, the result is `next_ip` plus `disp[31:0]` sign-extended. The base, index, `disp_en` and `disp_wide` inputs are ignored in this mode.
- R6: When `mode` is 2, the result is `disp[31:0]` sign-extended to 64 bits, so only the low 2 GB and the top 2 GB of the space can be reached.
- R7: `addr_valid` is high for exactly the one cycle after a clock edge where `req` is 1 and `lea` is 0. Both strobes are low in the cycle after a clock edge where `req` is 0.
- R8: A request with `lea` equal to 1 puts its result on `lea_data` with `lea_valid` high one cycle later. In that case `addr_valid` stays low and `addr` keeps its previous value.
- R9: All sums wrap modulo 2^64 and give no overflow indication.
- R10: A synchronous reset (`rst` high at a clock edge) clears both strobes and both result registers to zero, even if a request is present at that edge.
- R11: `addr` and `lea_data` keep their values until a request of their own kind updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe |
| lea | input | 1 | 1: arithmetic result, 0: memory address |
| mode | input | 2 | 0/3 general, 1 next-instruction relative, 2 absolute |
| base_en | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 4 | Index register number (4 means no index) |
| idx_val | input | 64 | Index register value |
| scale | input | 2 | Scale as a shift amount |
| disp_en | input | 1 | Offset term present (general mode) |
| disp_wide | input | 1 | 0: 8-bit offset, 1: 32-bit offset |
| disp | input | 32 | Offset or absolute constant |
| next_ip | input | 64 | Address of the following instruction |
| addr_valid | output | 1 | Address strobe |
| addr | output | 64 | Computed address |
| lea_valid | output | 1 | Arithmetic result strobe |
| lea_data | output | 64 | Computed sum returned as data |

## Verification
Every result is due exactly one clock after the edge that accepts the request. One clock after that, both strobes must be low again and both result registers must still hold their values. The bench drives each request just after a falling edge and drops `req` shortly after the next rising edge. It then samples the outputs 2 ns after that rising edge, and again 2 ns after the rising edge that follows. As a result, every comparison falls on the single cycle where its result is due, or on the idle cycle right after it.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW     = 64,
  parameter int RW     = 4,
  parameter int SP_NUM = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          lea,
  input  logic [1:0]    mode,
  input  logic          base_en,
  input  logic [AW-1:0] base_val,
  input  logic          idx_en,
  input  logic [RW-1:0] idx_sel,
  input  logic [AW-1:0] idx_val,
  input  logic [1:0]    scale,
  input  logic          disp_en,
  input  logic          disp_wide,
  input  logic [31:0]   disp,
  input  logic [AW-1:0] next_ip,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          lea_valid,
  output logic [AW-1:0] lea_data
);
  localparam logic [1:0]    M_IPREL = 2'd1;
  localparam logic [1:0]    M_ABS   = 2'd2;
  localparam logic [RW-1:0] SP_SEL  = RW'(SP_NUM);

  logic          idx_live;
  logic [AW-1:0] off8, off32, t_base, t_idx, t_off, ea;

  assign idx_live = idx_en && (idx_sel != SP_SEL);
  assign off8     = {{(AW-8){disp[7]}}, disp[7:0]};
  assign off32    = {{(AW-32){disp[31]}}, disp};
  assign t_base   = base_en  ? base_val : '0;
  assign t_idx    = idx_live ? (idx_val << scale) : '0;
  assign t_off    = disp_en  ? (disp_wide ? off32 : off8) : '0;

  always_comb begin
    case (mode)
      M_IPREL: ea = next_ip + off32;
      M_ABS:   ea = off32;
      default: ea = t_base + t_idx + t_off;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      lea_valid  <= 1'b0;
      addr       <= '0;
      lea_data   <= '0;
    end else begin
      addr_valid <= req && !lea;
      lea_valid  <= req && lea;
      if (req && !lea) addr     <= ea;
      if (req && lea)  lea_data <= ea;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW     = 64,
  parameter int RW     = 4,
  parameter int SP_NUM = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          lea,
  input logic [1:0]    mode,
  input logic          base_en,
  input logic          idx_en,
  input logic [RW-1:0] idx_sel,
  input logic          disp_en,
  input logic [31:0]   disp,
  input logic [AW-1:0] next_ip,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          lea_valid,
  input logic [AW-1:0] lea_data
);
  // R7
  addr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    req && !lea |=> addr_valid && !lea_valid);

  // R7
  idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !addr_valid && !lea_valid);

  // R8
  lea_path_chk: assert property (@(posedge clk) disable iff (rst)
    req && lea |=> lea_valid && !addr_valid && $stable(addr));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(addr) && $stable(lea_data));

  // R6
  absolute_chk: assert property (@(posedge clk) disable iff (rst)
    req && !lea && mode == 2'd2 |=>
      addr == {{(AW-32){$past(disp[31])}}, $past(disp)});

  // R5
  ip_relative_chk: assert property (@(posedge clk) disable iff (rst)
    req && !lea && mode == 2'd1 |=>
      addr == $past(next_ip) + {{(AW-32){$past(disp[31])}}, $past(disp)});

  // R3
  sp_no_index_chk: assert property (@(posedge clk) disable iff (rst)
    req && !lea && mode == 2'd0 && !base_en && !disp_en && idx_en &&
    idx_sel == RW'(SP_NUM) |=> addr == '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !addr_valid && !lea_valid && addr == '0 && lea_data == '0);
endmodule

bind addr_gen_unit agu_chk #(.AW(AW), .RW(RW), .SP_NUM(SP_NUM)) u_chk (
  .clk(clk), .rst(rst), .req(req), .lea(lea), .mode(mode),
  .base_en(base_en), .idx_en(idx_en), .idx_sel(idx_sel),
  .disp_en(disp_en), .disp(disp), .next_ip(next_ip),
  .addr_valid(addr_valid), .addr(addr),
  .lea_valid(lea_valid), .lea_data(lea_data)
);

// File: tb/sim_addr_gen_unit.sv
module sim_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, lea = 1'b0;
  logic [1:0]  mode = '0, scale = '0;
  logic        base_en = 1'b0, idx_en = 1'b0, disp_en = 1'b0, disp_wide = 1'b0;
  logic [63:0] base_val = '0, idx_val = '0, next_ip = '0;
  logic [3:0]  idx_sel = '0;
  logic [31:0] disp = '0;
  logic        addr_valid, lea_valid;
  logic [63:0] addr, lea_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] exp_addr = '0, exp_lea = '0, rs = 64'h9E3779B97F4A7C15;

  addr_gen_unit u0 (
    .clk(clk), .rst(rst), .req(req), .lea(lea), .mode(mode),
    .base_en(base_en), .base_val(base_val), .idx_en(idx_en), .idx_sel(idx_sel),
    .idx_val(idx_val), .scale(scale), .disp_en(disp_en), .disp_wide(disp_wide),
    .disp(disp), .next_ip(next_ip), .addr_valid(addr_valid), .addr(addr),
    .lea_valid(lea_valid), .lea_data(lea_data)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    return x ^ (x << 17);
  endfunction

  function automatic logic [63:0] model(
      input logic [1:0] m, input logic be, input logic [63:0] b,
      input logic ie, input logic [3:0] s, input logic [63:0] iv,
      input logic [1:0] sc, input logic de, input logic dw,
      input logic [31:0] d, input logic [63:0] nip);
    logic [63:0] d32, d8, sum;
    d32 = 64'(signed'(d));
    d8  = 64'(signed'(d[7:0]));
    if (m == 2'd1) return nip + d32;
    if (m == 2'd2) return d32;
    sum = 64'd0;
    if (be) sum = sum + b;
    if (ie && s != 4'd4) sum = sum + iv * (64'd1 << sc);
    if (de) sum = sum + (dw ? d32 : d8);
    return sum;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic l, input logic [1:0] m, input logic be,
      input logic [63:0] b, input logic ie, input logic [3:0] s,
      input logic [63:0] iv, input logic [1:0] sc, input logic de,
      input logic dw, input logic [31:0] d, input logic [63:0] nip,
      input string tag);
    logic [63:0] e;
    e = model(m, be, b, ie, s, iv, sc, de, dw, d, nip);
    lea = l; mode = m; base_en = be; base_val = b; idx_en = ie; idx_sel = s;
    idx_val = iv; scale = sc; disp_en = de; disp_wide = dw; disp = d; next_ip = nip;
    req = 1'b1;
    @(posedge clk); #2;
    req = 1'b0;
    if (!l) begin
      chk(tag, addr, e);
      chk("R7", 64'(addr_valid), 64'd1);
      chk("R7", 64'(lea_valid), 64'd0);
      exp_addr = e;
    end else begin
      chk(tag, lea_data, e);
      chk("R8", 64'(lea_valid), 64'd1);
      chk("R8", 64'(addr_valid), 64'd0);
      chk("R8", addr, exp_addr);
      exp_lea = e;
    end
    @(posedge clk); #2;
    chk("R7", 64'(addr_valid), 64'd0);
    chk("R7", 64'(lea_valid), 64'd0);
    chk("R11", addr, exp_addr);
    chk("R11", lea_data, exp_lea);
    @(negedge clk);
  endtask

  initial begin
    int n;
    string tg;
    repeat (3) @(posedge clk);
    #2;
    chk("R10", 64'(addr_valid), 64'd0);
    chk("R10", 64'(lea_valid), 64'd0);
    chk("R10", addr, 64'd0);
    chk("R10", lea_data, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    n = 0;
    for (int sc = 0; sc < 4; sc++)
      for (int s = 0; s < 16; s++)
        for (int f = 0; f < 16; f++) begin
          rs = nxt(rs);
          if (f[1] && s == 4) tg = "R3";
          else if (f[1]) tg = "R2";
          else if (f[2]) tg = "R4";
          else tg = "R1";
          issue(n % 3 == 2, (n % 7 == 0) ? 2'd3 : 2'd0, f[0], rs,
                f[1], 4'(s), {rs[31:0], rs[63:32]} ^ 64'h00FF, 2'(sc),
                f[2], f[3], (n % 2 == 0) ? rs[47:16] : {24'h0, rs[7:0] | 8'h80},
                64'h0, tg);
          n++;
        end

    for (int k = 0; k < 40; k++) begin
      rs = nxt(rs);
      issue(k % 4 == 3, 2'd1, 1'b1, rs, 1'b1, 4'd1, ~rs, 2'd3, 1'b0, 1'b0,
            (k % 2 == 0) ? rs[31:0] : (rs[31:0] | 32'h8000_0000), nxt(rs), "R5");
      rs = nxt(rs);
      issue(k % 4 == 1, 2'd2, 1'b1, rs, 1'b1, 4'd2, rs, 2'd2, 1'b0, 1'b0,
            (k % 2 == 0) ? (rs[31:0] & 32'h7FFF_FFFF) : (rs[31:0] | 32'h8000_0000),
            rs, "R6");
    end

    issue(1'b0, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd1,
          64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 1'b0, 32'h0000_007F, 64'h0, "R9");
    issue(1'b1, 2'd1, 1'b0, 64'h0, 1'b0, 4'd0, 64'h0, 2'd0, 1'b0, 1'b0,
          32'h0000_0010, 64'hFFFF_FFFF_FFFF_FFF8, "R9");
    issue(1'b0, 2'd0, 1'b0, 64'h0, 1'b1, 4'd4, 64'h1234, 2'd3, 1'b0, 1'b0,
          32'h0, 64'h0, "R3");

    lea = 1'b0; mode = 2'd0; base_en = 1'b1; base_val = 64'h55; req = 1'b1;
    rst = 1'b1;
    @(posedge clk); #2;
    req = 1'b0;
    chk("R10", 64'(addr_valid), 64'd0);
    chk("R10", 64'(lea_valid), 64'd0);
    chk("R10", addr, 64'd0);
    chk("R10", lea_data, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    exp_addr = '0;
    exp_lea = '0;
    issue(1'b0, 2'd2, 1'b0, 64'h0, 1'b0, 4'd0, 64'h0, 2'd0, 1'b0, 1'b0,
          32'h8000_0000, 64'h0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule